// File: doc/BRIEF.md
# Embedded-Timing Video Stream Decoder

This block sits behind a double-rate 4:2:2 video input that carries no separate sync or data-enable wires. Luma and chroma words alternate on one bus, and all of the line and frame timing travels in-band as four-word timing reference codes. The decoder looks for those codes and reads the status word that ends each one. It rebuilds horizontal sync, vertical sync, field and data-enable from the status flags alone.

The active words arrive in the order Cb, Y, Cr, Y. The decoder splits them into parallel Y, Cb and Cr outputs with a pixel-valid strobe, so each pixel comes out with both chroma samples of its pair. The bus width is a parameter (8, 10 or 12 bits). Timing codes are always recognised on the eight most significant bits. A status word whose protection bits do not match is reported and then dropped.

Top module: `emb_sync_dec`

## Requirements
- R1: A timing reference is recognised only when the upper eight bits of four consecutive words are 0xFF, 0x00, 0x00 and then a status word. The lower bits of a wider bus are ignored for this match.
- R2: In the upper eight bits of the status word, bit 6 is F, bit 5 is V and bit 4 is H. After a status word with correct protection bits, `field`, `vsync` and `hsync` equal F, V and H from the next cycle onward.
- R3: The protection bits sit in status bits 3..0 and must equal {V^H, F^H, F^V, F^V^H}. On a mismatch, `par_err` is high for exactly the one cycle after the status word, and `field`, `vsync`, `hsync` and `de` keep their previous values.
- R4: `de` is high in the cycle after each active input word. The active words are those that follow a valid status word with H=0 and V=0, up to but not including the next word whose upper byte is 0xFF.
- R5: A valid status word with H=0 and V=1 does not open an active region, so `de` stays low while `vsync` is high.
- R6: Active words are taken as Cb, Y, Cr, Y. In the cycle after each Cr word, `pix_vld` is high with the preceding Y, that Cb and that Cr. In the cycle after the second Y word, `pix_vld` is high with that Y and the same Cb and Cr.
- R7: `pix_vld` is never high unless the previous input word was active, and it is never high for three cycles in a row.
- R8: During and right after reset, every output is zero.
- R9: Y, Cb and Cr come out at the full parameterised bus width, including the low-order bits.
- R10: A sequence 0xFF, 0x00 followed directly by a status-like word is not a timing reference and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_in | input | DATA_W | Interleaved luma/chroma words and timing codes |
| hsync | output | 1 | H flag of the last valid status word |
| vsync | output | 1 | V flag of the last valid status word |
| field | output | 1 | F flag of the last valid status word |
| de | output | 1 | High one cycle after each active input word |
| pix_vld | output | 1 | Strobe for a complete output pixel |
| y_out | output | DATA_W | Luma sample of the pixel |
| cb_out | output | DATA_W | Blue-difference sample of the pixel pair |
| cr_out | output | DATA_W | Red-difference sample of the pixel pair |
| par_err | output | 1 | One-cycle pulse on a status word with bad protection bits |

## Verification
The stream runs on a 10-bit bus and starts with a vertical-blank line, so the bench can show that a start code with V=1 raises `vsync` and leaves `de` low. An active line with distinct, non-zero low bits in every sample then tells a correct Cb/Y/Cr/Y pairing and full-width output apart from swapped or truncated samples. A status word with wrong protection bits, followed by an ordinary word, separates error reporting from any change of flags. A preamble that is one zero word short checks that only the full four-word sequence is taken. A second-field line that ends after a single pixel pair checks that `field` and the early end of `de` both follow the codes.

// File: rtl/esd_pkg.sv
package esd_pkg;
  localparam int          CODE_W   = 8;
  localparam int          PRE_LEN  = 3;
  localparam logic [7:0]  PRE_ONES = 8'hFF;
  localparam logic [7:0]  PRE_ZERO = 8'h00;

  typedef struct packed {
    logic       f;
    logic       v;
    logic       h;
    logic [3:0] p;
  } tstat_t;

  typedef enum logic [1:0] {
    PH_CB  = 2'd0,
    PH_YA  = 2'd1,
    PH_CR  = 2'd2,
    PH_YB  = 2'd3
  } phase_e;

  // split the upper byte of a status word into its flags
  function automatic tstat_t unpack_status(input logic [7:0] xy);
    tstat_t s;
    s.f = xy[6];
    s.v = xy[5];
    s.h = xy[4];
    s.p = xy[3:0];
    return s;
  endfunction

  // protection bits expected for a given flag triple
  function automatic logic [3:0] prot_bits(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/esd_trs_find.sv
module esd_trs_find
  import esd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic              hit,
  output logic              is_ff,
  output logic              par_ok,
  output tstat_t            st
);
  localparam int LSB = DATA_W - CODE_W;

  logic [CODE_W-1:0]  code;
  logic [CODE_W-1:0]  hist [PRE_LEN];
  logic [PRE_LEN-1:0] stage_ok;

  assign code = din[DATA_W-1:LSB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PRE_LEN; i++) hist[i] <= PRE_ZERO;
    end else begin
      hist[0] <= code;
      for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
    end
  end

  // oldest stage must be all ones, the newer ones all zeros
  for (genvar g = 0; g < PRE_LEN; g++) begin : g_stage
    if (g == PRE_LEN - 1) begin : g_ones
      assign stage_ok[g] = (hist[g] == PRE_ONES);
    end else begin : g_zero
      assign stage_ok[g] = (hist[g] == PRE_ZERO);
    end
  end

  assign hit    = &stage_ok;
  assign is_ff  = (code == PRE_ONES);
  assign st     = unpack_status(code);
  assign par_ok = (st.p == prot_bits(st.f, st.v, st.h));

  // R1: a match needs the all-ones word three words back
  p_hit_needs_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_ff |=> !hit);
endmodule

// File: rtl/esd_timing.sv
module esd_timing
  import esd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hit,
  input  logic   is_ff,
  input  logic   par_ok,
  input  tstat_t st,
  output logic   sav_ok,
  output logic   word_act,
  output logic   hsync,
  output logic   vsync,
  output logic   field,
  output logic   de,
  output logic   par_err
);
  logic act_q;
  logic good_code;
  logic bad_code;

  assign good_code = hit && par_ok;
  assign bad_code  = hit && !par_ok;
  assign sav_ok    = good_code && !st.h && !st.v;
  assign word_act  = act_q && !is_ff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      field   <= 1'b0;
      de      <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (is_ff)       act_q <= 1'b0;
      else if (sav_ok) act_q <= 1'b1;
      if (good_code) begin
        hsync <= st.h;
        vsync <= st.v;
        field <= st.f;
      end
      de      <= word_act;
      par_err <= bad_code;
    end
  end

  p_flags_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    good_code |=> (hsync == $past(st.h)) && (vsync == $past(st.v)) && (field == $past(st.f)));

  p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !good_code |=> $stable(hsync) && $stable(vsync) && $stable(field));

  p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> par_err);

  p_de_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_ff |=> !de);

  p_no_de_vblank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !vsync);
endmodule

// File: rtl/esd_demux.sv
module esd_demux
  import esd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              word_act,
  input  logic              sav_ok,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] cb_out,
  output logic [DATA_W-1:0] cr_out,
  output logic              pix_vld
);
  phase_e            phase;
  logic [DATA_W-1:0] cb_hold;
  logic [DATA_W-1:0] cr_hold;
  logic [DATA_W-1:0] y_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_CB;
      cb_hold <= '0;
      cr_hold <= '0;
      y_hold  <= '0;
      y_out   <= '0;
      cb_out  <= '0;
      cr_out  <= '0;
      pix_vld <= 1'b0;
    end else begin
      pix_vld <= 1'b0;
      if (sav_ok) begin
        phase <= PH_CB;
      end else if (word_act) begin
        phase <= phase_e'(phase + 2'd1);
        unique case (phase)
          PH_CB: cb_hold <= din;
          PH_YA: y_hold  <= din;
          PH_CR: begin
            cr_hold <= din;
            y_out   <= y_hold;
            cb_out  <= cb_hold;
            cr_out  <= din;
            pix_vld <= 1'b1;
          end
          PH_YB: begin
            y_out   <= din;
            cb_out  <= cb_hold;
            cr_out  <= cr_hold;
            pix_vld <= 1'b1;
          end
        endcase
      end
    end
  end

  p_vld_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld && $past(pix_vld) |=> !pix_vld);

  p_vld_in_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> $past(word_act));
endmodule

// File: rtl/emb_sync_dec.sv
module emb_sync_dec
  import esd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] vid_in,
  output logic              hsync,
  output logic              vsync,
  output logic              field,
  output logic              de,
  output logic              pix_vld,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] cb_out,
  output logic [DATA_W-1:0] cr_out,
  output logic              par_err
);
  logic   code_hit;
  logic   code_ff;
  logic   code_par_ok;
  tstat_t code_st;
  logic   sav_ok;
  logic   word_act;

  esd_trs_find #(.DATA_W(DATA_W)) u_find (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (vid_in),
    .hit    (code_hit),
    .is_ff  (code_ff),
    .par_ok (code_par_ok),
    .st     (code_st)
  );

  esd_timing u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (code_hit),
    .is_ff    (code_ff),
    .par_ok   (code_par_ok),
    .st       (code_st),
    .sav_ok   (sav_ok),
    .word_act (word_act),
    .hsync    (hsync),
    .vsync    (vsync),
    .field    (field),
    .de       (de),
    .par_err  (par_err)
  );

  esd_demux #(.DATA_W(DATA_W)) u_demux (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (vid_in),
    .word_act (word_act),
    .sav_ok   (sav_ok),
    .y_out    (y_out),
    .cb_out   (cb_out),
    .cr_out   (cr_out),
    .pix_vld  (pix_vld)
  );

  // R8: outputs are quiet in the cycle after reset
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> !de && !pix_vld && !par_err && !hsync && !vsync && !field);
endmodule

// File: tb/emb_sync_dec_tb_top.sv
module emb_sync_dec_tb_top;
  localparam int W = 10;

  typedef struct packed {
    logic [W-1:0] w;
    logic hs, vs, fl, de, pv, pe;
    logic [W-1:0] y, cb, cr;
  } vec_t;

  localparam int NV = 48;
  // expected values are those seen in the cycle after the word is taken
  localparam vec_t VECS [NV] = '{
    '{10'h3FF,0,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,0,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,0,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h2AC,0,1,0,0,0,0,10'h0,10'h0,10'h0},   // start code in vblank (R5)
    '{10'h100,0,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h100,0,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h3FF,0,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,0,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,0,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h2D8,1,1,0,0,0,0,10'h0,10'h0,10'h0},   // end code in vblank
    '{10'h100,1,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h3FF,1,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,1,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,1,1,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h200,0,0,0,0,0,0,10'h0,10'h0,10'h0},   // active start (R2)
    '{10'h122,0,0,0,1,0,0,10'h0,10'h0,10'h0},
    '{10'h141,0,0,0,1,0,0,10'h0,10'h0,10'h0},
    '{10'h163,0,0,0,1,1,0,10'h141,10'h122,10'h163},
    '{10'h182,0,0,0,1,1,0,10'h182,10'h122,10'h163},
    '{10'h1A1,0,0,0,1,0,0,10'h0,10'h0,10'h0},
    '{10'h1C3,0,0,0,1,0,0,10'h0,10'h0,10'h0},
    '{10'h1E2,0,0,0,1,1,0,10'h1C3,10'h1A1,10'h1E2},
    '{10'h0F1,0,0,0,1,1,0,10'h0F1,10'h1A1,10'h1E2},
    '{10'h3FF,0,0,0,0,0,0,10'h0,10'h0,10'h0},   // de drops on preamble (R4)
    '{10'h001,0,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,0,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h274,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h100,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h3FF,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h204,1,0,0,0,0,1,10'h0,10'h0,10'h0},   // bad protection bits (R3)
    '{10'h100,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h3FF,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h200,1,0,0,0,0,0,10'h0,10'h0,10'h0},   // short preamble (R10)
    '{10'h100,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h3FF,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,1,0,0,0,0,0,10'h0,10'h0,10'h0},
    '{10'h31C,0,0,1,0,0,0,10'h0,10'h0,10'h0},   // second field start
    '{10'h122,0,0,1,1,0,0,10'h0,10'h0,10'h0},
    '{10'h141,0,0,1,1,0,0,10'h0,10'h0,10'h0},
    '{10'h163,0,0,1,1,1,0,10'h141,10'h122,10'h163},
    '{10'h3FF,0,0,1,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,0,0,1,0,0,0,10'h0,10'h0,10'h0},
    '{10'h001,0,0,1,0,0,0,10'h0,10'h0,10'h0},
    '{10'h274,1,0,0,0,0,0,10'h0,10'h0,10'h0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] vid_in = '0;
  logic         hsync, vsync, field, de, pix_vld, par_err;
  logic [W-1:0] y_out, cb_out, cr_out;
  int           total = 0;
  int           bad = 0;

  always #10 clk = ~clk;

  emb_sync_dec #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .vid_in(vid_in),
    .hsync(hsync), .vsync(vsync), .field(field), .de(de),
    .pix_vld(pix_vld), .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
    .par_err(par_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_quiet(input string req);
    check(req, {hsync, vsync, field, de, pix_vld, par_err}, 32'h0);
    check(req, {y_out, cb_out, cr_out}, 32'h0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_quiet("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R8 after reset");

    for (int i = 0; i < NV; i++) begin
      vid_in = VECS[i].w;
      @(negedge clk);
      check("R1/R2/R10 flags", {hsync, vsync, field}, {VECS[i].hs, VECS[i].vs, VECS[i].fl});
      check("R4/R5 de", de, VECS[i].de);
      check("R6/R7 pix_vld", pix_vld, VECS[i].pv);
      check("R3 par_err", par_err, VECS[i].pe);
      if (VECS[i].pv)
        check("R6/R9 pixel", {y_out, cb_out, cr_out}, {VECS[i].y, VECS[i].cb, VECS[i].cr});
    end

    // reset in the middle of an active line
    vid_in = 10'h3FF; @(negedge clk);
    vid_in = 10'h001; @(negedge clk);
    vid_in = 10'h001; @(negedge clk);
    vid_in = 10'h200; @(negedge clk);
    vid_in = 10'h122; @(negedge clk);
    check("R4 de before reset", de, 1'b1);
    rst_n = 1'b0;
    vid_in = 10'h141;
    @(negedge clk);
    check_quiet("R8 mid-line reset");
    rst_n = 1'b1;
    vid_in = 10'h163;
    @(negedge clk);
    check_quiet("R8 no resume after reset");

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule